// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block holds the interrupt master enable of a small processor core and its low-power halt state. The core reports each retired instruction with a one-cycle pulse and a tag that marks it as disable-interrupts, enable-interrupts, return-from-interrupt, halt, or any other instruction. The block also takes the interrupt enable and interrupt request vectors. From these it produces the master enable, a halted indication, an interrupt-dispatch request, and a flag that tells the fetch unit to skip one program-counter increment.

Enabling interrupts is delayed. The master enable rises only after the instruction that follows the enable instruction has retired. A return-from-interrupt sets the enable at once. A halt retired while the enable is clear and a request is already pending does not stop the core. Instead it raises the increment-suppress flag, so the next opcode byte is fetched twice. The core signals the start of an interrupt service with a dispatch pulse. That pulse clears the enable and cancels any delayed enable.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, ime_o, halted_o and pc_hold_o are 0.
- R2: A retire with op_i=1 (disable) clears ime_o on the following cycle. It also cancels an outstanding delayed enable, so a later plain retire does not set ime_o.
- R3: A retire with op_i=2 (enable) leaves ime_o unchanged on the following cycle. ime_o becomes 1 in the cycle after the next retire of any tag other than 1.
- R4: A retire with op_i=3 (return-from-interrupt) sets ime_o on the following cycle, with no delay.
- R5: irq_req_o equals ime_o AND (the OR over bits of ie_i & if_i), with no register delay.
- R6: A dispatch_i pulse clears ime_o on the following cycle and cancels any outstanding delayed enable. dispatch_i has priority over a retire in the same cycle.
- R7: A retire with op_i=4 (halt) while the master enable after that retire is 1 sets halted_o on the following cycle. pc_hold_o stays 0.
- R8: A halt retired with the enable clear and nothing pending sets halted_o. irq_req_o stays 0 while halted and after waking.
- R9: A halt retired with the enable clear and a request pending leaves halted_o at 0 and sets pc_hold_o on the following cycle. pc_hold_o clears in the cycle after the next retire.
- R10: While halted, halted_o falls in the cycle after ie_i & if_i is first seen non-zero. This holds whatever the state of the enable.
- R11: A halt that directly follows an enable retire sees the enable as set, because the halt itself completes the delay. It therefore halts even with a request pending and wakes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One-cycle pulse per retired instruction |
| op_i | input | 3 | Tag of the retired instruction: 0 other, 1 disable, 2 enable, 3 return-from-interrupt, 4 halt |
| dispatch_i | input | 1 | Core starts interrupt service |
| ie_i | input | 8 | Interrupt enable vector |
| if_i | input | 8 | Interrupt request vector |
| ime_o | output | 1 | Master interrupt enable |
| halted_o | output | 1 | Core is halted |
| irq_req_o | output | 1 | Request to dispatch an interrupt |
| pc_hold_o | output | 1 | Suppress the next program-counter increment |

## Verification
The hardest states to reach are those where the delayed enable overlaps another event. Examples are a disable, a dispatch or a halt arriving while the delay is still outstanding, and the double-fetch halt, which needs the enable clear and a request already pending at the moment the halt retires. Directed sequences build each of these states in order: enable followed by disable, enable followed by dispatch, enable followed by halt with a request pending, and disable plus a raised request followed by halt. A long seeded random run of tags, dispatches and vectors then checks every output each cycle against a reference model in the bench. In that run, retires are suppressed while the core is halted and dispatch is issued only while it is requested.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_DI    = 3'd1,
    OP_EI    = 3'd2,
    OP_RETI  = 3'd3,
    OP_HALT  = 3'd4
  } op_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] ie_i,
  input  logic [NUM_IRQ-1:0] if_i,
  output logic               pending_o
);
  logic [NUM_IRQ-1:0] hit;
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    assign hit[g] = ie_i[g] & if_i[g];
  end
  assign pending_o = |hit;
endmodule

// File: rtl/ime_ctrl.sv
module ime_ctrl
  import irq_halt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  op_e  op_i,
  input  logic dispatch_i,
  output logic ime_o,
  output logic ime_nx_o
);
  logic ime_q, ei_q, ei_nx;

  always_comb begin
    ime_nx_o = ime_q;
    ei_nx    = ei_q;
    if (dispatch_i) begin
      ime_nx_o = 1'b0;
      ei_nx    = 1'b0;
    end else if (retire_i) begin
      unique case (op_i)
        OP_DI:   begin ime_nx_o = 1'b0;         ei_nx = 1'b0; end
        OP_EI:   begin ime_nx_o = ime_q | ei_q; ei_nx = 1'b1; end
        OP_RETI: begin ime_nx_o = 1'b1;         ei_nx = 1'b0; end
        default: begin ime_nx_o = ime_q | ei_q; ei_nx = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q <= 1'b0;
      ei_q  <= 1'b0;
    end else begin
      ime_q <= ime_nx_o;
      ei_q  <= ei_nx;
    end
  end

  assign ime_o = ime_q;

  a_r2_di_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && op_i == OP_DI |=> !ime_q && !ei_q);
  a_r4_reti_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && op_i == OP_RETI && !dispatch_i |=> ime_q);
  a_r6_dispatch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_i |=> !ime_q && !ei_q);
  a_r3_ei_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && op_i == OP_EI && !dispatch_i && !ime_q && !ei_q |=> !ime_q && ei_q);
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic is_halt_i,
  input  logic ime_nx_i,
  input  logic pending_i,
  output logic halted_o,
  output logic pc_hold_o
);
  logic halted_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (halted_q && pending_i)
        halted_q <= 1'b0;
      else if (retire_i && is_halt_i && (ime_nx_i || !pending_i))
        halted_q <= 1'b1;
      if (retire_i)
        hold_q <= is_halt_i && !ime_nx_i && pending_i;
    end
  end

  assign halted_o  = halted_q;
  assign pc_hold_o = hold_q;

  a_r9_hold_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !halted_q);
  a_r10_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q && pending_i |=> !halted_q);
  a_r7_halt_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && is_halt_i && ime_nx_i && !halted_q |=> halted_q && !hold_q);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_halt_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               retire_i,
  input  logic [2:0]         op_i,
  input  logic               dispatch_i,
  input  logic [NUM_IRQ-1:0] ie_i,
  input  logic [NUM_IRQ-1:0] if_i,
  output logic               ime_o,
  output logic               halted_o,
  output logic               irq_req_o,
  output logic               pc_hold_o
);
  op_e  op;
  logic pending, ime_nx;

  assign op = op_e'(op_i);

  irq_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .ie_i(ie_i), .if_i(if_i), .pending_o(pending)
  );

  ime_ctrl u_ime (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i), .op_i(op),
    .dispatch_i(dispatch_i), .ime_o(ime_o), .ime_nx_o(ime_nx)
  );

  halt_ctrl u_halt (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i),
    .is_halt_i(op == OP_HALT), .ime_nx_i(ime_nx), .pending_i(pending),
    .halted_o(halted_o), .pc_hold_o(pc_hold_o)
  );

  assign irq_req_o = ime_o & pending;

  a_r8_no_req_ime_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ime_o |-> !irq_req_o);
endmodule

// File: tb/tb_irq_halt_ctrl.sv
`timescale 1ns/1ps
module tb_irq_halt_ctrl;
  logic clk = 0, rst_n = 0;
  logic retire = 0, dispatch = 0;
  logic [2:0] op = 0;
  logic [7:0] ie = 0, ifl = 0;
  logic ime, halted, req, hold;
  int checks = 0, errors = 0;
  bit m_ime = 0, m_ei = 0, m_halt = 0, m_hold = 0;

  always #2 clk = ~clk;

  irq_halt_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .op_i(op),
    .dispatch_i(dispatch), .ie_i(ie), .if_i(ifl), .ime_o(ime),
    .halted_o(halted), .irq_req_o(req), .pc_hold_o(hold)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic bit pend_f(logic [7:0] a, logic [7:0] b);
    return |(a & b);
  endfunction

  // reference model update for one clock edge
  task automatic model(bit r, logic [2:0] o, bit d, bit p);
    bit ni, ne;
    ni = m_ime; ne = m_ei;
    if (d) begin ni = 0; ne = 0; end
    else if (r) begin
      case (o)
        3'd1: begin ni = 0; ne = 0; end
        3'd2: begin ni = m_ime | m_ei; ne = 1; end
        3'd3: begin ni = 1; ne = 0; end
        default: begin ni = m_ime | m_ei; ne = 0; end
      endcase
    end
    if (m_halt && p) m_halt = 0;
    else if (r && o == 3'd4 && (ni || !p)) m_halt = 1;
    if (r) m_hold = (o == 3'd4) && !ni && p;
    m_ime = ni; m_ei = ne;
  endtask

  task automatic step(bit r, logic [2:0] o, bit d, logic [7:0] e, logic [7:0] f, string tag);
    @(negedge clk);
    retire = r; op = o; dispatch = d; ie = e; ifl = f;
    #1 chk("R5", {tag, " irq_req"}, req, m_ime & pend_f(e, f));
    @(posedge clk);
    model(r, o, d, pend_f(e, f));
    #1;
    chk(tag, "ime", ime, m_ime);
    chk(tag, "halted", halted, m_halt);
    chk(tag, "pc_hold", hold, m_hold);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R1", "ime reset", ime, 0);
    chk("R1", "halted reset", halted, 0);
    chk("R1", "pc_hold reset", hold, 0);
    rst_n = 1;
    idle("R1");
    // R3: delayed enable
    step(1, 2, 0, 0, 0, "R3");
    chk("R3", "ime after EI", ime, 0);
    step(1, 0, 0, 0, 0, "R3");
    chk("R3", "ime after next", ime, 1);
    // R2: DI clears; cancels delay
    step(1, 1, 0, 0, 0, "R2");
    chk("R2", "ime after DI", ime, 0);
    step(1, 2, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");
    chk("R2", "delay cancelled", ime, 0);
    // R4
    step(1, 3, 0, 0, 0, "R4");
    chk("R4", "ime after RETI", ime, 1);
    // R5 / R6
    step(0, 0, 0, 8'h05, 8'h04, "R5");
    chk("R5", "req pending", req, 1);
    step(0, 0, 1, 8'h05, 8'h04, "R6");
    chk("R6", "ime after dispatch", ime, 0);
    step(1, 2, 0, 0, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");
    step(1, 0, 0, 0, 0, "R6");
    chk("R6", "delay cancelled by dispatch", ime, 0);
    // R7 / R10
    step(1, 3, 0, 0, 0, "R7");
    step(1, 4, 0, 8'hFF, 8'h00, "R7");
    chk("R7", "halted", halted, 1);
    idle("R7");
    step(0, 0, 0, 8'h10, 8'h10, "R10");
    chk("R10", "woken", halted, 0);
    step(0, 0, 1, 8'h10, 8'h10, "R10");
    // R8
    step(1, 1, 0, 0, 0, "R8");
    step(1, 4, 0, 8'h01, 8'h02, "R8");
    chk("R8", "halted", halted, 1);
    step(0, 0, 0, 8'h02, 8'h02, "R8");
    chk("R8", "woken", halted, 0);
    chk("R8", "no req", req, 0);
    // R9
    step(1, 4, 0, 8'h08, 8'h08, "R9");
    chk("R9", "not halted", halted, 0);
    chk("R9", "hold set", hold, 1);
    step(1, 0, 0, 0, 0, "R9");
    chk("R9", "hold cleared", hold, 0);
    // R11
    step(1, 2, 0, 8'h01, 8'h01, "R11");
    step(1, 4, 0, 8'h01, 8'h01, "R11");
    chk("R11", "halted with ime", halted, 1);
    chk("R11", "ime set", ime, 1);
    chk("R11", "no hold", hold, 0);
    step(0, 0, 0, 8'h01, 8'h01, "R11");
    chk("R11", "woken", halted, 0);
    step(0, 0, 1, 0, 0, "R11");
    // random run
    for (int i = 0; i < 4000; i++) begin
      bit r, d;
      logic [2:0] o;
      logic [7:0] e, f;
      e = 8'($urandom);
      f = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      o = 3'($urandom % 5);
      r = !m_halt && ($urandom % 4 != 0);
      d = m_ime && pend_f(e, f) && !m_halt && ($urandom % 2 == 0);
      if (d) r = 0;
      step(r, o, d, e, f, "RND");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule